// File: doc/BRIEF.md
# Split-Offset Call and Branch Redirect Unit

This block computes the program-counter redirects for the short branches of a 16-bit instruction set and for its long call, which is split across two consecutive halfword instructions. The first halfword of the call carries the upper part of the displacement. It only forms an intermediate value from the current PC and parks it in the link register. The second halfword adds its lower displacement to that parked value to reach the target. In the same step it writes a return address, marked with bit 0 set, back into the link register and asks for a pipeline flush.

The pipeline hands the block one decoded instruction per cycle. Each instruction arrives with its kind, its offset field, a condition verdict, the already-advanced PC and the register-file copy of the link register. All results appear one clock later as registered write strobes and values, plus a flush pulse. The link write of the previous instruction may not yet be visible in the register-file copy. For that case the block feeds its own last link write forward, so that the two halves of a call can be issued back to back.

Top module: `br_link_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, all outputs (`lr_we_o`, `lr_wdata_o`, `pc_we_o`, `pc_wdata_o`, `flush_o`) are zero.
- R2: A valid first call half (`kind_i` = 2'b10) sign-extends the 11-bit offset, shifts it left by 12 and adds PC. The next cycle shows this value on `lr_wdata_o` with `lr_we_o` high, `pc_we_o` low and `flush_o` low.
- R3: A valid second call half (`kind_i` = 2'b11) zero-extends the 11-bit offset, shifts it left by 1 and adds the effective link value. The next cycle shows this value on `pc_wdata_o` with `pc_we_o` high.
- R4: In that same cycle, the second call half writes (PC − 2) with bit 0 forced to 1 to the link register, and `flush_o` is high.
- R5: A valid unconditional branch (`kind_i` = 2'b01) redirects to PC plus the sign-extended 11-bit offset shifted left by 1, with flush and without a link write.
- R6: A valid conditional branch (`kind_i` = 2'b00) whose condition passes uses only offset bits [7:0]. It sign-extends them, shifts left by 1, adds PC, and redirects with flush.
- R7: A conditional branch whose condition fails raises no write strobe and no flush.
- R8: When the output cycle of one instruction carries a link write, the instruction issued in that cycle uses `lr_wdata_o` as its link value instead of `lr_i`.
- R9: All address sums and the PC − 2 difference wrap modulo 2^32.
- R10: A cycle with `valid_i` low produces no write strobe and no flush in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| kind_i | input | 2 | 00 conditional, 01 unconditional, 10 call upper half, 11 call lower half |
| off_i | input | 11 | Offset field of the instruction |
| cond_pass_i | input | 1 | Condition verdict for a conditional branch |
| pc_i | input | 32 | Advanced PC of the instruction |
| lr_i | input | 32 | Link register value from the register file |
| lr_we_o | output | 1 | Link register write strobe |
| lr_wdata_o | output | 32 | Link register write value |
| pc_we_o | output | 1 | PC redirect strobe |
| pc_wdata_o | output | 32 | New PC |
| flush_o | output | 1 | Pipeline flush pulse |

## Verification
Two functions can overlap in one cycle. The link write of the upper call half is still on the outputs in the cycle when the lower half is issued and reads the link value. The bench provokes this by issuing the two halves on consecutive cycles while `lr_i` carries a deliberately wrong value. It also issues two lower halves in a row, so that a return address is forwarded as well. The reference model judges the redirect against the forwarded value, not `lr_i`. An idle cycle placed between halves shows the non-forwarded path.

// File: rtl/brl_pkg.sv
package brl_pkg;

  typedef enum logic [1:0] {
    BK_COND    = 2'b00,
    BK_JUMP    = 2'b01,
    BK_LINK_HI = 2'b10,
    BK_LINK_LO = 2'b11
  } br_kind_e;

endpackage

// File: rtl/brl_lr_bypass.sv
module brl_lr_bypass #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] rf_lr,
  input  logic              own_we,
  input  logic [ADDR_W-1:0] own_data,
  output logic [ADDR_W-1:0] lr_eff
);
  // The block's own last link write is newer than the register file copy.
  always_comb begin
    lr_eff = own_we ? own_data : rf_lr;
  end
endmodule

// File: rtl/brl_target_calc.sv
module brl_target_calc
  import brl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned COFF_W = 8
) (
  input  br_kind_e          kind,
  input  logic [OFF_W-1:0]  off,
  input  logic              cond_pass,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr_eff,
  output logic              do_lr,
  output logic [ADDR_W-1:0] lr_val,
  output logic              do_pc,
  output logic [ADDR_W-1:0] pc_val
);
  localparam int unsigned HI_SH = OFF_W + 1;

  function automatic logic [ADDR_W-1:0] disp_short(input logic [OFF_W-1:0] v);
    return {{(ADDR_W-OFF_W-1){v[OFF_W-1]}}, v, 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] disp_upper(input logic [OFF_W-1:0] v);
    return {{(ADDR_W-OFF_W-HI_SH){v[OFF_W-1]}}, v, {HI_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] disp_lower(input logic [OFF_W-1:0] v);
    return {{(ADDR_W-OFF_W-1){1'b0}}, v, 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] disp_cond(input logic [COFF_W-1:0] v);
    return {{(ADDR_W-COFF_W-1){v[COFF_W-1]}}, v, 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] ret_tag(input logic [ADDR_W-1:0] p);
    logic [ADDR_W-1:0] d;
    d = p - ADDR_W'(2);
    return {d[ADDR_W-1:1], 1'b1};
  endfunction

  always_comb begin
    do_lr  = 1'b0;
    lr_val = '0;
    do_pc  = 1'b0;
    pc_val = '0;
    unique case (kind)
      BK_COND: begin
        do_pc  = cond_pass;
        pc_val = cond_pass ? pc + disp_cond(off[COFF_W-1:0]) : '0;
      end
      BK_JUMP: begin
        do_pc  = 1'b1;
        pc_val = pc + disp_short(off);
      end
      BK_LINK_HI: begin
        do_lr  = 1'b1;
        lr_val = pc + disp_upper(off);
      end
      BK_LINK_LO: begin
        do_pc  = 1'b1;
        pc_val = lr_eff + disp_lower(off);
        do_lr  = 1'b1;
        lr_val = ret_tag(pc);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/br_link_unit.sv
module br_link_unit
  import brl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned COFF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              cond_pass_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] lr_i,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_wdata_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_wdata_o,
  output logic              flush_o
);
  br_kind_e          kind_e;
  logic [ADDR_W-1:0] lr_eff;
  logic              do_lr, do_pc;
  logic [ADDR_W-1:0] lr_val, pc_val;

  // Named events for the assertions.
  logic ev_hi, ev_lo, ev_jump, ev_cond_fail, ev_idle;

  assign kind_e       = br_kind_e'(kind_i);
  assign ev_hi        = valid_i && (kind_e == BK_LINK_HI);
  assign ev_lo        = valid_i && (kind_e == BK_LINK_LO);
  assign ev_jump      = valid_i && (kind_e == BK_JUMP);
  assign ev_cond_fail = valid_i && (kind_e == BK_COND) && !cond_pass_i;
  assign ev_idle      = !valid_i;

  brl_lr_bypass #(.ADDR_W(ADDR_W)) u_bypass (
    .rf_lr    (lr_i),
    .own_we   (lr_we_o),
    .own_data (lr_wdata_o),
    .lr_eff   (lr_eff)
  );

  brl_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .COFF_W(COFF_W)) u_calc (
    .kind      (kind_e),
    .off       (off_i),
    .cond_pass (cond_pass_i),
    .pc        (pc_i),
    .lr_eff    (lr_eff),
    .do_lr     (do_lr),
    .lr_val    (lr_val),
    .do_pc     (do_pc),
    .pc_val    (pc_val)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lr_we_o    <= 1'b0;
      lr_wdata_o <= '0;
      pc_we_o    <= 1'b0;
      pc_wdata_o <= '0;
      flush_o    <= 1'b0;
    end else begin
      lr_we_o    <= valid_i && do_lr;
      lr_wdata_o <= (valid_i && do_lr) ? lr_val : '0;
      pc_we_o    <= valid_i && do_pc;
      pc_wdata_o <= (valid_i && do_pc) ? pc_val : '0;
      flush_o    <= valid_i && do_pc;
    end
  end

  a_r2_hi_no_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_hi |=> (lr_we_o && !pc_we_o && !flush_o));

  a_r4_lo_tagged_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_lo |=> (lr_we_o && lr_wdata_o[0] && pc_we_o && flush_o));

  a_r5_jump_no_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_jump |=> (pc_we_o && flush_o && !lr_we_o));

  a_r7_cond_fail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_cond_fail |=> (!lr_we_o && !pc_we_o && !flush_o));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_idle |=> (!lr_we_o && !pc_we_o && !flush_o));
endmodule

// File: tb/br_link_unit_tb_top.sv
`timescale 1ns/1ps
module br_link_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [1:0]  kind;
  logic [10:0] off;
  logic        pass;
  logic [31:0] pc, lr;
  logic        lr_we, pc_we, flush;
  logic [31:0] lr_wd, pc_wd;

  int checks = 0;
  int errors = 0;

  logic        e_lrwe, e_pcwe, e_fl;
  logic [31:0] e_lr, e_pc;

  always #10 clk = ~clk;

  br_link_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .kind_i(kind), .off_i(off),
    .cond_pass_i(pass), .pc_i(pc), .lr_i(lr),
    .lr_we_o(lr_we), .lr_wdata_o(lr_wd), .pc_we_o(pc_we), .pc_wdata_o(pc_wd),
    .flush_o(flush)
  );

  task automatic chk(input string tag);
    checks++;
    if (lr_we !== e_lrwe || lr_wd !== e_lr || pc_we !== e_pcwe ||
        pc_wd !== e_pc || flush !== e_fl) begin
      errors++;
      $display("FAIL %s: got lr_we=%0b lr=%h pc_we=%0b pc=%h flush=%0b exp lr_we=%0b lr=%h pc_we=%0b pc=%h flush=%0b",
               tag, lr_we, lr_wd, pc_we, pc_wd, flush, e_lrwe, e_lr, e_pcwe, e_pc, e_fl);
    end
  endtask

  // Reference model: one issue, one clock, compare at the next falling edge.
  task automatic issue(input bit v, input logic [1:0] k, input logic [10:0] o,
                       input bit p, input logic [31:0] pcv, input logic [31:0] lrv,
                       input string tag);
    int s11, s8;
    logic [31:0] src;
    logic n_lrwe = 0, n_pcwe = 0, n_fl = 0;
    logic [31:0] n_lr = 0, n_pc = 0;
    src = e_lrwe ? e_lr : lrv;
    s11 = int'(o);  if (o[10]) s11 -= 2048;
    s8  = int'(o[7:0]); if (o[7]) s8 -= 256;
    if (v) begin
      case (k)
        2'b00: if (p) begin n_pcwe = 1; n_fl = 1; n_pc = pcv + 32'(s8 * 2); end
        2'b01: begin n_pcwe = 1; n_fl = 1; n_pc = pcv + 32'(s11 * 2); end
        2'b10: begin n_lrwe = 1; n_lr = pcv + 32'(s11 * 4096); end
        default: begin
          n_pcwe = 1; n_fl = 1; n_pc = src + 32'(o) * 32'd2;
          n_lrwe = 1; n_lr = (pcv - 32'd2) | 32'd1;
        end
      endcase
    end
    valid = v; kind = k; off = o; pass = p; pc = pcv; lr = lrv;
    @(posedge clk);
    @(negedge clk);
    e_lrwe = n_lrwe; e_lr = n_lr; e_pcwe = n_pcwe; e_pc = n_pc; e_fl = n_fl;
    chk(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; valid = 0; kind = 0; off = 0; pass = 0; pc = 0; lr = 0;
    e_lrwe = 0; e_lr = 0; e_pcwe = 0; e_pc = 0; e_fl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset");
    rst_n = 1;
    issue(0, 2'b11, 11'h7FF, 1, 32'h1234_5678, 32'h1111_1110, "R1 after reset");
    // R2 upper call half
    issue(1, 2'b10, 11'h005, 0, 32'h0800_0004, 32'h0, "R2 positive");
    issue(1, 2'b10, 11'h7FF, 0, 32'h1000_0000, 32'h0, "R2 negative");
    // R10 idle with busy inputs
    issue(0, 2'b01, 11'h100, 1, 32'h4000_0000, 32'h0, "R10 idle");
    // R3/R4 lower half without forwarding
    issue(1, 2'b11, 11'h7FF, 0, 32'h0000_0100, 32'h0001_0000, "R3 R4 lower half");
    issue(0, 2'b00, 11'h000, 0, 32'h0, 32'h0, "R10 gap");
    issue(1, 2'b11, 11'h002, 0, 32'h0000_0000, 32'h0000_8000, "R4 R9 pc zero");
    // R8 back-to-back halves, stale lr_i
    issue(0, 2'b00, 11'h000, 0, 32'h0, 32'h0, "R10 gap");
    issue(1, 2'b10, 11'h001, 0, 32'h2000_0000, 32'hDEAD_BEE0, "R2 before forward");
    issue(1, 2'b11, 11'h010, 0, 32'h2000_0002, 32'hDEAD_BEE0, "R8 forwarded upper");
    issue(1, 2'b11, 11'h004, 0, 32'h2000_1024, 32'hDEAD_BEE0, "R8 forwarded return");
    // R5 unconditional
    issue(1, 2'b01, 11'h100, 0, 32'h0000_0100, 32'h0, "R5 forward jump");
    issue(1, 2'b01, 11'h7FE, 0, 32'h0000_0100, 32'h0, "R5 backward jump");
    // R9 wrap
    issue(1, 2'b01, 11'h010, 0, 32'hFFFF_FFF0, 32'h0, "R9 jump wrap");
    issue(1, 2'b10, 11'h001, 0, 32'hFFFF_F000, 32'h0, "R9 upper wrap");
    issue(0, 2'b00, 11'h000, 0, 32'h0, 32'h0, "R10 gap");
    // R6/R7 conditional
    issue(1, 2'b00, 11'h480, 1, 32'h0000_1000, 32'h0, "R6 negative, upper bits ignored");
    issue(1, 2'b00, 11'h07F, 1, 32'h0000_1000, 32'h0, "R6 positive");
    issue(1, 2'b00, 11'h07F, 0, 32'h0000_1000, 32'h0, "R7 condition fails");
    issue(1, 2'b00, 11'h3FF, 0, 32'h8000_0000, 32'h0, "R7 condition fails again");
    issue(0, 2'b00, 11'h000, 0, 32'h0, 32'h0, "R10 final idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule